// File: doc/BRIEF.md
# Dual-Stream Commit Consistency Checker

This block sits beside a processor core that runs two interleaved copies of the same instruction sequence. One copy writes the lower half of the architectural register file and the other writes the upper half. The block watches the commit port, where each retiring instruction is tagged either original or duplicate, and keeps a separate running count for each stream. Whenever the two counts agree, every lower-half register must hold the same value as its partner sixteen places above it. Any disagreement points to a logic error in the core. No golden model is needed for this.

The block also holds a small four-state reset sequencer. It drives the core's reset and raises a done signal once the core is out of reset. Comparison is enabled only after that point. A detected mismatch is latched until the next reset, together with the lowest pair index that differed.

Top module: `dup_commit_checker`

## Requirements
- R1: The sequencer starts in its first state while rst_ni is low. core_rst_o is high in that state and after the first clock edge that follows the release of rst_ni. It goes low after the second edge.
- R2: rst_done_o is low until the third clock edge after rst_ni is released. It then goes high and stays high until rst_ni is asserted again.
- R3: While rst_done_o is low, no register difference sets mismatch_o.
- R4: Each commit slot s with commit_valid_i[s]=1 adds one to the duplicate count when commit_dup_i[s]=1 and one to the original count when it is 0. Both slots can retire in the same cycle, and both count.
- R5: While the original and duplicate counts differ, a register difference does not set mismatch_o.
- R6: The register file arrives flat on regs_i, with register r at bits r*XLEN +: XLEN. Suppose rst_done_o is high and the counts are equal in a cycle where register k differs from register k+16 for some k in 1..15. Then mismatch_o is high after the next clock edge.
- R7: A difference between register 0 and register 16 never sets mismatch_o.
- R8: Once set, mismatch_o stays high until rst_ni is asserted. mismatch_idx_o holds the lowest k whose pair differed in the detecting cycle, and later differences do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| commit_valid_i | input | SLOTS | Per-slot commit valid |
| commit_dup_i | input | SLOTS | Per-slot tag: 1 means duplicate, 0 means original |
| regs_i | input | NREGS*XLEN | Flattened architectural register file |
| core_rst_o | output | 1 | Reset driven into the core |
| rst_done_o | output | 1 | Core reset sequence complete; enables checking |
| mismatch_o | output | 1 | Sticky consistency failure flag |
| mismatch_idx_o | output | $clog2(NREGS/2) | Lowest failing lower-half register index |

## Verification
Some behaviours are checked by assertions on every cycle:
- core reset is low whenever done is high, and done never falls without a reset;
- the flag cannot rise from a cycle with done low or with unequal counts;
- the flag and its index hold once set, and the index is never zero.

Other behaviours only the bench scenarios can show:
- the exact cycles of the reset sequence;
- that two commits in one cycle both count;
- that the flag rises on the edge after the counts become equal;
- that the index picks the lowest pair among several differing pairs, including the boundary pairs 1 and 15;
- that the register 0 and 16 pair is ignored.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    SEQ_I  = 2'd0,
    SEQ_S1 = 2'd1,
    SEQ_S2 = 2'd2,
    SEQ_S3 = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dcc_rst_seq.sv
module dcc_rst_seq
  import dcc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output logic core_rst_o,
  output logic rst_done_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      SEQ_I:   state_d = SEQ_S1;
      SEQ_S1:  state_d = SEQ_S2;
      SEQ_S2:  state_d = SEQ_S3;
      default: state_d = SEQ_S3;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_I;
    else         state_q <= state_d;
  end

  assign core_rst_o = (state_q == SEQ_I) || (state_q == SEQ_S1);
  assign rst_done_o = (state_q == SEQ_S3);
endmodule

// File: rtl/dcc_commit_cnt.sv
module dcc_commit_cnt #(
  parameter int SLOTS = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] valid_i,
  input  logic [SLOTS-1:0] dup_i,
  output logic [CNT_W-1:0] orig_cnt_o,
  output logic [CNT_W-1:0] dup_cnt_o
);
  localparam int INC_W = $clog2(SLOTS + 1);

  logic [INC_W-1:0] orig_inc, dup_inc;
  logic [CNT_W-1:0] orig_q, dup_q;

  always_comb begin
    orig_inc = '0;
    dup_inc  = '0;
    for (int s = 0; s < SLOTS; s++) begin
      orig_inc = orig_inc + INC_W'(valid_i[s] && !dup_i[s]);
      dup_inc  = dup_inc  + INC_W'(valid_i[s] &&  dup_i[s]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      orig_q <= '0;
      dup_q  <= '0;
    end else begin
      orig_q <= orig_q + CNT_W'(orig_inc);
      dup_q  <= dup_q  + CNT_W'(dup_inc);
    end
  end

  assign orig_cnt_o = orig_q;
  assign dup_cnt_o  = dup_q;
endmodule

// File: rtl/dcc_pair_cmp.sv
module dcc_pair_cmp #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic [NREGS*XLEN-1:0]        regs_i,
  output logic                         any_o,
  output logic [$clog2(NREGS/2)-1:0]   low_idx_o
);
  localparam int HALF  = NREGS / 2;
  localparam int IDX_W = $clog2(HALF);

  logic [HALF-1:0] diff, masked;

  for (genvar k = 0; k < HALF; k++) begin : g_pair
    assign diff[k] = regs_i[k*XLEN +: XLEN] != regs_i[(k+HALF)*XLEN +: XLEN];
  end

  // pair 0 holds the hardwired zero register
  assign masked = diff & ~{{(HALF-1){1'b0}}, 1'b1};
  assign any_o  = |masked;

  always_comb begin
    low_idx_o = '0;
    for (int k = HALF - 1; k >= 1; k--) begin
      if (masked[k]) low_idx_o = IDX_W'(k);
    end
  end
endmodule

// File: rtl/dup_commit_checker.sv
module dup_commit_checker #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int SLOTS = 2,
  parameter int CNT_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [SLOTS-1:0]            commit_valid_i,
  input  logic [SLOTS-1:0]            commit_dup_i,
  input  logic [NREGS*XLEN-1:0]       regs_i,
  output logic                        core_rst_o,
  output logic                        rst_done_o,
  output logic                        mismatch_o,
  output logic [$clog2(NREGS/2)-1:0]  mismatch_idx_o
);
  localparam int IDX_W = $clog2(NREGS / 2);

  logic [CNT_W-1:0] orig_cnt, dup_cnt;
  logic             cnt_eq, check_en, pair_bad;
  logic [IDX_W-1:0] pair_idx;
  logic             mm_q;
  logic [IDX_W-1:0] idx_q;

  dcc_rst_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .core_rst_o (core_rst_o),
    .rst_done_o (rst_done_o)
  );

  dcc_commit_cnt #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (commit_valid_i),
    .dup_i      (commit_dup_i),
    .orig_cnt_o (orig_cnt),
    .dup_cnt_o  (dup_cnt)
  );

  dcc_pair_cmp #(.XLEN(XLEN), .NREGS(NREGS)) u_cmp (
    .regs_i    (regs_i),
    .any_o     (pair_bad),
    .low_idx_o (pair_idx)
  );

  assign cnt_eq   = (orig_cnt == dup_cnt);
  assign check_en = rst_done_o && cnt_eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mm_q  <= 1'b0;
      idx_q <= '0;
    end else if (!mm_q && check_en && pair_bad) begin
      mm_q  <= 1'b1;
      idx_q <= pair_idx;
    end
  end

  assign mismatch_o     = mm_q;
  assign mismatch_idx_o = idx_q;
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             core_rst_o,
  input logic             rst_done_o,
  input logic             mismatch_o,
  input logic [IDX_W-1:0] mismatch_idx_o,
  input logic             cnt_eq_i
);
  AST_DONE_NO_CORE_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_done_o |-> !core_rst_o); // R1
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_done_o |=> rst_done_o); // R2
  AST_NO_FLAG_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_done_o && !mismatch_o) |=> !mismatch_o); // R3
  AST_NO_FLAG_UNEQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_eq_i && !mismatch_o) |=> !mismatch_o); // R5
  AST_IDX_NOT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> (mismatch_idx_o != '0)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |=> (mismatch_o && $stable(mismatch_idx_o))); // R8
endmodule

bind dup_commit_checker dcc_checker #(.IDX_W(IDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .core_rst_o     (core_rst_o),
  .rst_done_o     (rst_done_o),
  .mismatch_o     (mismatch_o),
  .mismatch_idx_o (mismatch_idx_o),
  .cnt_eq_i       (cnt_eq)
);

// File: tb/dup_commit_checker_test.sv
`timescale 1ns/1ps
module dup_commit_checker_test;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int SLOTS = 2;
  localparam int HALF  = NREGS / 2;
  localparam int IDX_W = $clog2(HALF);

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [SLOTS-1:0]      commit_valid_i = '0;
  logic [SLOTS-1:0]      commit_dup_i = '0;
  logic [NREGS*XLEN-1:0] regs_i = '0;
  logic                  core_rst_o, rst_done_o, mismatch_o;
  logic [IDX_W-1:0]      mismatch_idx_o;

  int checks = 0;
  int errors = 0;
  int seq = 0;
  int oc = 0;
  int dc = 0;
  bit e_mm = 1'b0;
  int e_idx = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  dup_commit_checker #(.XLEN(XLEN), .NREGS(NREGS), .SLOTS(SLOTS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .commit_valid_i(commit_valid_i),
    .commit_dup_i(commit_dup_i), .regs_i(regs_i), .core_rst_o(core_rst_o),
    .rst_done_o(rst_done_o), .mismatch_o(mismatch_o), .mismatch_idx_o(mismatch_idx_o)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_reg(input int r, input logic [XLEN-1:0] v);
    regs_i[r*XLEN +: XLEN] = v;
  endtask

  function automatic logic [XLEN-1:0] get_reg(input int r);
    return regs_i[r*XLEN +: XLEN];
  endfunction

  task automatic fill_consistent();
    for (int k = 0; k < HALF; k++) begin
      logic [XLEN-1:0] v = $urandom;
      set_reg(k, v);
      set_reg(k + HALF, v);
    end
  endtask

  function automatic int lowest_bad();
    for (int k = 1; k < HALF; k++)
      if (get_reg(k) != get_reg(k + HALF)) return k;
    return 0;
  endfunction

  task automatic check_outputs();
    check(int'(core_rst_o), int'(seq < 2), "R1");
    check(int'(rst_done_o), int'(seq == 3), "R2");
    check(int'(mismatch_o), int'(e_mm), tag);
    if (e_mm) check(int'(mismatch_idx_o), e_idx, "R8");
  endtask

  task automatic cycle();
    if (rst_ni) begin
      if (seq == 3 && oc == dc && !e_mm && lowest_bad() != 0) begin
        e_mm  = 1'b1;
        e_idx = lowest_bad();
      end
      for (int s = 0; s < SLOTS; s++)
        if (commit_valid_i[s]) begin
          if (commit_dup_i[s]) dc++;
          else oc++;
        end
      if (seq < 3) seq++;
    end
    @(posedge clk);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic commit(input logic [SLOTS-1:0] v, input logic [SLOTS-1:0] d);
    commit_valid_i = v;
    commit_dup_i   = d;
    cycle();
    commit_valid_i = '0;
    commit_dup_i   = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    commit_valid_i = '0;
    commit_dup_i = '0;
    seq = 0; oc = 0; dc = 0; e_mm = 1'b0; e_idx = 0;
    #1;
    tag = "R8";
    check_outputs();
    cycle();
    rst_ni = 1'b1;
  endtask

  task automatic bring_up();
    do_reset();
    fill_consistent();
    repeat (3) cycle();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    // R1 R2 R3: sequence timing, flag masked before done
    fill_consistent();
    do_reset();
    tag = "R3";
    set_reg(21, get_reg(5) ^ 32'h1);
    cycle(); cycle(); cycle();
    fill_consistent();
    cycle(); cycle();

    // R4 R5: dual-slot counting, no flag while counts differ
    tag = "R5";
    commit(2'b11, 2'b00);
    set_reg(19, get_reg(3) ^ 32'h80);
    cycle(); cycle();
    commit(2'b01, 2'b01);
    commit(2'b11, 2'b10);
    cycle();
    tag = "R4";
    commit(2'b01, 2'b01);
    tag = "R6";
    cycle(); cycle();
    check(int'(mismatch_idx_o), 3, "R6");

    // R7: zero pair ignored; lowest index wins; R8 sticky index
    bring_up();
    tag = "R7";
    set_reg(16, get_reg(0) ^ 32'hFFFF);
    cycle(); cycle();
    tag = "R6";
    set_reg(25, ~get_reg(9));
    set_reg(20, ~get_reg(4));
    cycle();
    tag = "R8";
    fill_consistent();
    set_reg(18, ~get_reg(2));
    cycle(); cycle();
    check(int'(mismatch_idx_o), 4, "R8");

    // boundary pairs 15 and 1
    bring_up();
    tag = "R6";
    set_reg(31, ~get_reg(15));
    cycle(); cycle();
    bring_up();
    set_reg(17, ~get_reg(1));
    cycle(); cycle();

    // constrained random mix
    bring_up();
    tag = "R4/R5/R6";
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 63);
      commit_valid_i = SLOTS'($urandom);
      commit_dup_i   = SLOTS'($urandom);
      if (r < 6) set_reg($urandom_range(HALF, NREGS - 1), $urandom);
      else if (r < 14) fill_consistent();
      if (r == 63) begin
        bring_up();
        tag = "R4/R5/R6";
      end else cycle();
    end
    commit_valid_i = '0;
    commit_dup_i = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule